// File: doc/BRIEF.md
# Scatter-Gather DMA Channel Sequencer

This block sequences one DMA channel through a chain of tasks kept in memory. Two descriptors sit at fixed addresses in the control area: a primary one and an alternate one. Each descriptor holds a source end pointer, a destination end pointer and a 32-bit control word. In a scatter-gather chain the primary descriptor does not move payload data. It acts as a loader. On each pass it copies four words from a task list into the alternate slot, and the alternate descriptor then runs that task as an ordinary copy.

Two chain flavours exist, and they differ only in when the channel gives up the bus. In the peripheral flavour, each task waits for a peripheral request and is then loaded and executed under a single grant. In the memory flavour, no request is needed; instead the channel re-arbitrates after the loader pass and after every burst of the task. The chain ends with a one-cycle done pulse when a task whose control word marks it as basic has finished. A control word the sequencer does not accept raises a sticky fault and leaves the channel idle.

The bus fabric and the arbiter are outside the block. It sees them as a request/grant pair and as a simple memory port whose read data arrives one cycle after the request.

Top module: `sgdma_seq`

## Requirements
- R1: After synchronous reset, `arb_req`, `mem_req`, `done` and `fault` are low.
- R2: A `start` pulse while idle clears `fault`, raises `arb_req` and, once granted, reads the primary descriptor at byte offsets 0, 4 and 8 from `PRI_BASE` (source end, destination end, control). Control word fields: cycle code [2:0], count-minus-one [13:4], burst exponent [17:14], transfer size [25:24], source step [27:26], destination step [31:30]. Bits 3, 23:18 and 29:28 are reserved.
- R3: The primary cycle code 3'b100 selects the memory flavour, and 3'b110 or 3'b111 selects the peripheral flavour. Any other code, or any reserved bit set, raises `fault` and makes no memory write.
- R4: A loader pass performs four word copies. Copy k (k = 0..3) reads from primary source end minus count times step and writes to primary destination end minus (3-k) times step. The primary count drops by one per copy. Step codes: 2'b00 = 1 byte, 2'b01 = 2, 2'b10 = 4, 2'b11 = no increment.
- R5: After each loader pass the primary control word is written back to `PRI_BASE`+8 with the count reduced by four. If the pass consumed the last group (the count was 3), it is written with count 0 and cycle code 3'b000 instead.
- R6: The task then reads the alternate descriptor at `ALT_BASE`+0/4/8 and performs count+1 beats. Each beat reads source end minus remaining count times step and writes destination end minus the same offset. Afterwards the alternate control word is written back with count 0 and cycle code 3'b000.
- R7: In peripheral flavour, `arb_req` stays low between tasks until `per_req` is seen high. It then stays high without a break from the first loader copy through the alternate write-back.
- R8: In memory flavour, no `per_req` is needed. `arb_req` drops for exactly one cycle after the primary write-back, and again after every 2^exponent task beats (the exponent taken from the alternate control word) while beats remain.
- R9: When the finished task's cycle code is basic (3'b001), `done` pulses high for exactly one cycle, with `arb_req` low.
- R10: A task whose cycle code is neither basic nor the continue code (3'b111 peripheral, 3'b101 memory) raises `fault` before any beat of that task. `fault` stays high until the next `start`, and `done` is not raised.
- R11: `mem_req` is only ever high while both `arb_req` and `arb_gnt` are high.
- R12: A task that asks to continue after the primary descriptor was written back as stopped raises `fault` instead of loading another task.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch the chain from idle |
| per_req | input | 1 | Peripheral request, level sampled while waiting between tasks |
| arb_req | output | 1 | Channel wants the bus |
| arb_gnt | input | 1 | Bus granted to this channel |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| done | output | 1 | One-cycle pulse at chain end |
| fault | output | 1 | Sticky configuration error |

## Verification
The hardest case to reach from the ports is a burst boundary in memory flavour that falls exactly on the last beat of a task. There the channel must go straight to write-back without an extra release. Failing that, the peripheral flavour must show no release at all between loader and task. The bench reaches both by sweeping the burst exponent over 0 to 2 against task lengths of 2 to 4 beats. It counts falling edges of `arb_req` against a count derived from those lengths. A grant model that delays every grant, and a request generator that pulses only now and then, make any early bus use or any start without a request visible.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  typedef struct packed {
    logic [1:0] dinc;
    logic [1:0] rsv_a;
    logic [1:0] sinc;
    logic [1:0] size;
    logic [5:0] rsv_b;
    logic [3:0] rpow;
    logic [9:0] nm1;
    logic       rsv_c;
    logic [2:0] cc;
  } ctl_t;

  localparam int CNT_W = 10;

  localparam logic [2:0] CC_STOP    = 3'b000;
  localparam logic [2:0] CC_BASIC   = 3'b001;
  localparam logic [2:0] CC_MEM_PRI = 3'b100;
  localparam logic [2:0] CC_MEM_ALT = 3'b101;
  localparam logic [2:0] CC_PER_PRI = 3'b110;
  localparam logic [2:0] CC_PER_ALT = 3'b111;

  localparam logic [1:0] STEP_NONE = 2'b11;

  typedef enum logic [3:0] {
    S_IDLE, S_ARB, S_DRD, S_DCAP, S_WAIT,
    S_CRD, S_CWT, S_CWR, S_PWB, S_GAP,
    S_BRD, S_BWT, S_BWR, S_AWB
  } state_t;

endpackage

// File: rtl/sgdma_addr_gen.sv
module sgdma_addr_gen #(
  parameter int AW = 16,
  parameter int CW = 10
) (
  input  logic [AW-1:0] end_addr,
  input  logic [CW-1:0] remain,
  input  logic [1:0]    step,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] rem_w;
  logic [AW-1:0] offset;

  assign rem_w = AW'(remain);

  always_comb begin
    case (step)
      2'b00:   offset = rem_w;
      2'b01:   offset = rem_w << 1;
      2'b10:   offset = rem_w << 2;
      default: offset = '0;
    endcase
  end

  assign addr = end_addr - offset;
endmodule

// File: rtl/sgdma_ctl_decode.sv
module sgdma_ctl_decode
  import sgdma_pkg::*;
(
  input  logic [2:0] cc,
  input  logic [8:0] rsv,
  input  logic       per_sel,
  output logic       pri_ok,
  output logic       pri_per,
  output logic       alt_basic,
  output logic       alt_cont
);
  assign pri_per   = (cc == CC_PER_PRI) || (cc == CC_PER_ALT);
  assign pri_ok    = ((cc == CC_MEM_PRI) || pri_per) && (rsv == '0);
  assign alt_basic = (cc == CC_BASIC);
  assign alt_cont  = per_sel ? (cc == CC_PER_ALT) : (cc == CC_MEM_ALT);
endmodule

// File: rtl/sgdma_seq.sv
module sgdma_seq
  import sgdma_pkg::*;
#(
  parameter int          AW       = 16,
  parameter logic [15:0] PRI_BASE = 16'h0000,
  parameter logic [15:0] ALT_BASE = 16'h0010,
  parameter int          BCW      = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          per_req,
  output logic          arb_req,
  input  logic          arb_gnt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          done,
  output logic          fault
);
  localparam logic [AW-1:0] PRI_A   = AW'(PRI_BASE);
  localparam logic [AW-1:0] ALT_A   = AW'(ALT_BASE);
  localparam logic [AW-1:0] CTL_OFS = AW'(8);

  state_t        state, arb_next;
  logic [1:0]    widx, grp;
  logic          desc_alt, per_mode, pri_stop;
  logic [AW-1:0] pri_src, pri_dst, alt_src, alt_dst;
  ctl_t          pri_ctl, alt_ctl;
  logic [2:0]    alt_cc;
  logic [31:0]   hold;
  logic [BCW-1:0] burst, burst_lim;
  logic          done_q, fault_q;

  ctl_t rd_ctl;
  logic dec_pri_ok, dec_pri_per, dec_alt_basic, dec_alt_cont;
  logic copy_ph;

  assign rd_ctl  = ctl_t'(mem_rdata);
  assign copy_ph = (state == S_CRD) || (state == S_CWT) || (state == S_CWR);
  assign burst_lim = BCW'(1) << alt_ctl.rpow;

  sgdma_ctl_decode u_dec (
    .cc        (rd_ctl.cc),
    .rsv       ({rd_ctl.rsv_a, rd_ctl.rsv_b, rd_ctl.rsv_c}),
    .per_sel   (per_mode),
    .pri_ok    (dec_pri_ok),
    .pri_per   (dec_pri_per),
    .alt_basic (dec_alt_basic),
    .alt_cont  (dec_alt_cont)
  );

  // index 0: source side, index 1: destination side
  logic [AW-1:0]    ag_end  [2];
  logic [CNT_W-1:0] ag_rem  [2];
  logic [1:0]       ag_step [2];
  logic [AW-1:0]    ag_addr [2];

  assign ag_end[0]  = copy_ph ? pri_src : alt_src;
  assign ag_rem[0]  = copy_ph ? pri_ctl.nm1 : alt_ctl.nm1;
  assign ag_step[0] = copy_ph ? pri_ctl.sinc : alt_ctl.sinc;
  assign ag_end[1]  = copy_ph ? pri_dst : alt_dst;
  assign ag_rem[1]  = copy_ph ? CNT_W'(2'd3 - grp) : alt_ctl.nm1;
  assign ag_step[1] = copy_ph ? pri_ctl.dinc : alt_ctl.dinc;

  for (genvar g = 0; g < 2; g++) begin : g_agen
    sgdma_addr_gen #(.AW(AW), .CW(CNT_W)) u_agen (
      .end_addr (ag_end[g]),
      .remain   (ag_rem[g]),
      .step     (ag_step[g]),
      .addr     (ag_addr[g])
    );
  end

  // bus side, decoded from registered state
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = hold;
    case (state)
      S_DRD: begin
        mem_req  = 1'b1;
        mem_addr = (desc_alt ? ALT_A : PRI_A) + AW'({widx, 2'b00});
      end
      S_CRD, S_BRD: begin
        mem_req  = 1'b1;
        mem_addr = ag_addr[0];
      end
      S_CWR, S_BWR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = ag_addr[1];
      end
      S_PWB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = PRI_A + CTL_OFS;
        mem_wdata = pri_ctl;
      end
      S_AWB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ALT_A + CTL_OFS;
        mem_wdata = alt_ctl;
      end
      default: ;
    endcase
  end

  assign arb_req = (state != S_IDLE) && (state != S_WAIT) && (state != S_GAP);
  assign done    = done_q;
  assign fault   = fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      arb_next <= S_IDLE;
      widx     <= '0;
      grp      <= '0;
      desc_alt <= 1'b0;
      per_mode <= 1'b0;
      pri_stop <= 1'b0;
      pri_src  <= '0;
      pri_dst  <= '0;
      alt_src  <= '0;
      alt_dst  <= '0;
      pri_ctl  <= '0;
      alt_ctl  <= '0;
      alt_cc   <= '0;
      hold     <= '0;
      burst    <= '0;
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          fault_q  <= 1'b0;
          desc_alt <= 1'b0;
          widx     <= '0;
          arb_next <= S_DRD;
          state    <= S_ARB;
        end
        S_ARB: if (arb_gnt) state <= arb_next;
        S_DRD: state <= S_DCAP;
        S_DCAP: begin
          if (widx != 2'd2) begin
            if (widx == 2'd0) begin
              if (desc_alt) alt_src <= mem_rdata[AW-1:0];
              else          pri_src <= mem_rdata[AW-1:0];
            end else begin
              if (desc_alt) alt_dst <= mem_rdata[AW-1:0];
              else          pri_dst <= mem_rdata[AW-1:0];
            end
            widx  <= widx + 2'd1;
            state <= S_DRD;
          end else if (!desc_alt) begin
            pri_ctl <= rd_ctl;
            if (dec_pri_ok) begin
              per_mode <= dec_pri_per;
              pri_stop <= 1'b0;
              state    <= S_WAIT;
            end else begin
              fault_q <= 1'b1;
              state   <= S_IDLE;
            end
          end else begin
            alt_ctl <= rd_ctl;
            alt_cc  <= rd_ctl.cc;
            burst   <= '0;
            if (dec_alt_basic || dec_alt_cont) state <= S_BRD;
            else begin
              fault_q <= 1'b1;
              state   <= S_IDLE;
            end
          end
        end
        S_WAIT: if (!per_mode || per_req) begin
          grp      <= '0;
          arb_next <= S_CRD;
          state    <= S_ARB;
        end
        S_CRD: state <= S_CWT;
        S_CWT: begin
          hold  <= mem_rdata;
          state <= S_CWR;
        end
        S_CWR: begin
          if (grp == 2'd3 && pri_ctl.nm1 == '0) begin
            pri_ctl.cc <= CC_STOP;
            pri_stop   <= 1'b1;
          end else begin
            pri_ctl.nm1 <= pri_ctl.nm1 - 1'b1;
          end
          grp   <= grp + 2'd1;
          state <= (grp == 2'd3) ? S_PWB : S_CRD;
        end
        S_PWB: begin
          desc_alt <= 1'b1;
          widx     <= '0;
          if (per_mode) state <= S_DRD;
          else begin
            arb_next <= S_DRD;
            state    <= S_GAP;
          end
        end
        S_GAP: state <= S_ARB;
        S_BRD: state <= S_BWT;
        S_BWT: begin
          hold  <= mem_rdata;
          state <= S_BWR;
        end
        S_BWR: begin
          if (alt_ctl.nm1 == '0) begin
            alt_ctl.cc <= CC_STOP;
            state      <= S_AWB;
          end else begin
            alt_ctl.nm1 <= alt_ctl.nm1 - 1'b1;
            if (!per_mode && burst == burst_lim - 1'b1) begin
              burst    <= '0;
              arb_next <= S_BRD;
              state    <= S_GAP;
            end else begin
              burst <= burst + 1'b1;
              state <= S_BRD;
            end
          end
        end
        S_AWB: begin
          if (alt_cc == CC_BASIC) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else if (pri_stop) begin
            fault_q <= 1'b1;
            state   <= S_IDLE;
          end else begin
            state <= S_WAIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgdma_seq_chk.sv
module sgdma_seq_chk
  import sgdma_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   start,
  input logic   arb_req,
  input logic   arb_gnt,
  input logic   mem_req,
  input logic   done,
  input logic   fault,
  input state_t state,
  input logic   per_mode
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!arb_req && !mem_req && !done && !fault)); // R1

  AST_BUS_GRANTED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (arb_req && arb_gnt)); // R11

  AST_NO_REARB_LOAD: assert property (@(posedge clk) disable iff (rst)
    (state == S_PWB && per_mode) |=> arb_req); // R7

  AST_MEM_GAP: assert property (@(posedge clk) disable iff (rst)
    (state == S_PWB && !per_mode) |=> !arb_req); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    done |-> !arb_req); // R9

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fault && !start) |=> fault); // R10

  AST_DONE_NOT_FAULT: assert property (@(posedge clk) disable iff (rst)
    done |-> !fault); // R10
endmodule

bind sgdma_seq sgdma_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .arb_req  (arb_req),
  .arb_gnt  (arb_gnt),
  .mem_req  (mem_req),
  .done     (done),
  .fault    (fault),
  .state    (state),
  .per_mode (per_mode)
);

// File: tb/sgdma_seq_test.sv
module sgdma_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int TLW = 64, SRCW = 256, DSTW = 512;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, per_req = 1'b0, arb_gnt = 1'b0;
  logic arb_req, mem_req, mem_we, done, fault;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;

  logic [31:0] mem [0:1023];
  int checks = 0, failures = 0;
  int done_cnt, falls, rises, bad_rises, wr_cnt, gnt_viol, log_n, gcnt, pcnt;
  logic [AW-1:0] acc_log [3];
  logic arb_prev = 1'b0, per_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgdma_seq #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .start(start), .per_req(per_req),
    .arb_req(arb_req), .arb_gnt(arb_gnt), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .fault(fault)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  // monitors first, then grant model and request generator
  always @(negedge clk) begin
    if (mem_req && !(arb_req && arb_gnt)) gnt_viol++;
    if (mem_req && mem_we) wr_cnt++;
    if (mem_req && log_n < 3) begin acc_log[log_n] = mem_addr; log_n++; end
    if (done) done_cnt++;
    if (arb_prev && !arb_req) falls++;
    if (!arb_prev && arb_req) begin
      if (rises > 0 && !per_req) bad_rises++;
      rises++;
    end
    arb_prev = arb_req;
    if (arb_req) begin gcnt++; arb_gnt = (gcnt >= 2); end
    else begin gcnt = 0; arb_gnt = 1'b0; end
    pcnt++;
    per_req = per_en && (pcnt % 23 == 0);
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctl(input logic [1:0] di, input logic [1:0] si,
      input logic [3:0] rp, input int n, input logic [2:0] cc);
    logic [9:0] n10 = n[9:0];
    return {di, 2'b00, si, 2'b10, 6'b0, rp, n10, 1'b0, cc};
  endfunction

  function automatic logic [1:0] sinc_of(input bit per, input int t);
    return (!per && t == 1) ? 2'b11 : 2'b10;
  endfunction

  function automatic logic [31:0] src_val(input int t, input int k);
    return 32'hA500_0000 | (t << 8) | k;
  endfunction

  task automatic prepare(input bit per, input int nt, input int r, input bit last_cont, input int bad_t);
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int t = 0; t < nt; t++) begin
      int b = 2 + t;
      logic [2:0] cc = (t == bad_t) ? 3'b011 :
                       (t == nt-1 && !last_cont) ? 3'b001 : (per ? 3'b111 : 3'b101);
      for (int k = 0; k < b; k++) mem[SRCW + 16*t + k] = src_val(t, k);
      mem[TLW + 4*t]     = (SRCW + 16*t + b - 1) * 4;
      mem[TLW + 4*t + 1] = (DSTW + 16*t + b - 1) * 4;
      mem[TLW + 4*t + 2] = mk_ctl(2'b10, sinc_of(per, t), 4'(r), b - 1, cc);
    end
    mem[0] = TLW*4 + 16*nt - 4;
    mem[1] = 16 + 12;
    mem[2] = mk_ctl(2'b10, 2'b10, 4'd2, 4*nt - 1, per ? 3'b110 : 3'b100);
    per_en = per;
  endtask

  task automatic launch();
    @(negedge clk);
    done_cnt = 0; falls = 0; rises = 0; bad_rises = 0; wr_cnt = 0; gnt_viol = 0; log_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 6000 && done_cnt == 0 && !fault; c++) @(negedge clk);
    repeat (3) @(negedge clk);
    per_en = 1'b0;
  endtask

  function automatic int data_errs(input bit per, input int t);
    int e = 0;
    int b = 2 + t;
    for (int k = 0; k < b; k++) begin
      logic [31:0] exp = (sinc_of(per, t) == 2'b11) ? src_val(t, b - 1) : src_val(t, k);
      if (mem[DSTW + 16*t + k] !== exp) e++;
    end
    return e;
  endfunction

  task automatic check_ok(input bit per, input int nt, input int r);
    int e = 0, exp_falls = 1;
    int lb = 2 + nt - 1;
    for (int t = 0; t < nt; t++) begin
      e += data_errs(per, t);
      if (!per) exp_falls += 2 + (((2 + t) + (1 << r) - 1) >> r) - 1;
      else exp_falls += 1;
    end
    chk(done_cnt == 1, "R9 done pulses", done_cnt, 1);
    chk(fault == 1'b0, "R10 no fault on good chain", fault, 0);
    chk(e == 0, "R6 moved data mismatches", e, 0);
    chk(mem[2] == mk_ctl(2'b10, 2'b10, 4'd2, 0, 3'b000), "R5 primary write-back", mem[2],
        mk_ctl(2'b10, 2'b10, 4'd2, 0, 3'b000));
    chk(mem[6] == mk_ctl(2'b10, sinc_of(per, nt-1), 4'(r), 0, 3'b000), "R6 alternate write-back",
        mem[6], mk_ctl(2'b10, sinc_of(per, nt-1), 4'(r), 0, 3'b000));
    chk(mem[4] == 32'((SRCW + 16*(nt-1) + lb - 1) * 4), "R4 alternate slot loaded", mem[4],
        (SRCW + 16*(nt-1) + lb - 1) * 4);
    chk(acc_log[0] == 0 && acc_log[1] == 4 && acc_log[2] == 8, "R2 primary read order",
        {acc_log[0], acc_log[1], acc_log[2]}, 48'h0000_0004_0008);
    chk(gnt_viol == 0, "R11 access without grant", gnt_viol, 0);
    chk(falls == exp_falls, per ? "R7 bus releases" : "R8 bus releases", falls, exp_falls);
    if (per) begin
      chk(bad_rises == 0, "R7 task start without request", bad_rises, 0);
      chk(rises == 1 + nt, "R7 bus requests", rises, 1 + nt);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!arb_req && !mem_req && !done && !fault, "R1 reset state",
        {arb_req, mem_req, done, fault}, 0);

    // peripheral chains of 1..3 tasks
    for (int nt = 1; nt <= 3; nt++) begin
      prepare(1'b1, nt, 0, 1'b0, -1);
      launch();
      check_ok(1'b1, nt, 0);
    end
    // memory chains: task count x burst exponent
    for (int r = 0; r <= 2; r++) begin
      for (int nt = 1; nt <= 3; nt++) begin
        prepare(1'b0, nt, r, 1'b0, -1);
        launch();
        check_ok(1'b0, nt, r);
      end
    end

    // R3: unsupported primary code
    prepare(1'b1, 2, 0, 1'b0, -1);
    mem[2] = mk_ctl(2'b10, 2'b10, 4'd2, 7, 3'b010);
    launch();
    chk(fault == 1'b1, "R3 bad primary code faults", fault, 1);
    chk(wr_cnt == 0, "R3 no writes after bad primary", wr_cnt, 0);

    // R3: reserved bit set
    prepare(1'b1, 2, 0, 1'b0, -1);
    mem[2] = mk_ctl(2'b10, 2'b10, 4'd2, 7, 3'b110) | 32'h8;
    launch();
    chk(fault == 1'b1, "R3 reserved bit faults", fault, 1);
    chk(done_cnt == 0, "R3 no done on fault", done_cnt, 0);

    // R10: bad task code
    prepare(1'b1, 2, 0, 1'b0, 0);
    launch();
    chk(fault == 1'b1, "R10 bad task code faults", fault, 1);
    chk(data_errs(1'b1, 0) == 2, "R10 faulting task moves nothing", data_errs(1'b1, 0), 2);
    chk(done_cnt == 0, "R10 no done with fault", done_cnt, 0);
    repeat (5) @(negedge clk);
    chk(fault == 1'b1, "R10 fault held while idle", fault, 1);

    // R12: continue requested with exhausted list
    prepare(1'b1, 1, 0, 1'b1, -1);
    launch();
    chk(fault == 1'b1, "R12 exhausted list faults", fault, 1);
    chk(data_errs(1'b1, 0) == 0, "R12 last task still moved", data_errs(1'b1, 0), 0);
    chk(done_cnt == 0, "R12 no done", done_cnt, 0);

    // restart after fault clears it
    prepare(1'b1, 2, 0, 1'b0, -1);
    launch();
    check_ok(1'b1, 2, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule